// File: doc/BRIEF.md
# Multiplexed Word Bus Interface

This block sits between a processor core and an external memory that is reached over one set of sixteen shared pins. The core asks for a byte or a word with a byte address, a write flag, a size flag and a one-cycle request strobe. The block then runs the pin sequence and answers with a single-cycle done pulse and, for reads, the data.

Each access starts with an address phase. ALE is high in that phase so that an external transparent latch can hold the word address. A data phase follows, and the bus then returns to idle. The external memory stores only whole words. A byte store therefore becomes a word read, a merge of the one target byte, and a word write. These three steps run back to back and the bus does not go idle between them. A two-bit input picks how the active-low write strobe lines up with the clock inside the write cycle.

Top module: `mux_word_bus`

## Requirements
- R1: While reset is held and right after it, ale is 0, oeN is 1, weN is 1, busDirIn is 1 (pins not driven) and rspDone is 0.
- R2: In the cycle after an idle block samples reqValid high, ale is 1 and busDirIn is 0. busOut[15:1] carries reqAddr[15:1], busOut[0] is 0, and oeN and weN are both 1.
- R3: A read runs its data phase in the cycle after the address phase, with oeN 0, busDirIn 1 and ale 0. rspDone is 1 in the next cycle, and a word read then shows the bus word on rspRdata.
- R4: A byte read returns the selected byte in rspRdata[7:0] with rspRdata[15:8] at 0. reqAddr[0]=0 selects bus bits [7:0] and reqAddr[0]=1 selects bus bits [15:8].
- R5: A word write runs its data phase in the cycle after the address phase. In that phase busDirIn is 0, oeN is 1, busOut carries reqWdata and weN is asserted. rspDone is 1 in the next cycle.
- R6: A byte write runs address, read and write phases in consecutive cycles and raises rspDone in the fourth cycle. The written word is reqWdata[7:0] in the lane chosen by reqAddr[0] (as in R4) and the word just read in the other lane. reqWdata[15:8] has no effect.
- R7: The write-phase weN shape follows weMode. 0 is low for the whole cycle, 1 is low only while clk is low, 2 is low only while clk is high, and 3 acts as 0.
- R8: rspDone lasts exactly one cycle. A reqValid seen while an access is in progress starts no access.
- R9: oeN and weN are never low together, and oeN is never low while ale is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe from the core |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByte | input | 1 | 1 = byte access, 0 = word access |
| reqAddr | input | 16 | Byte address |
| reqWdata | input | 16 | Write data; a byte write uses bits [7:0] |
| weMode | input | 2 | Write strobe shape select |
| rspRdata | output | 16 | Read result |
| rspDone | output | 1 | One-cycle completion pulse |
| busIn | input | 16 | Value seen on the shared pins |
| busOut | output | 16 | Value driven onto the shared pins |
| busDirIn | output | 1 | 0 = block drives the pins, 1 = pins are inputs |
| ale | output | 1 | Address latch enable, high in the address phase |
| oeN | output | 1 | Memory output enable, active low |
| weN | output | 1 | Memory write enable, active low |

## Verification
The hardest case to reach is a byte store whose merge must keep the neighbouring byte exactly as memory holds it. That case can only be seen when the untouched byte differs from whatever the core supplies. The stimulus first writes distinct word patterns, then overwrites each lane in turn with upper write-data bits set to junk, and reads the whole word back. The same stores run under each strobe shape. The bench memory commits data on the rising edge of weN, so a strobe that is mistimed or too short corrupts a later readback.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } mwb_state_e;

  // strobes from the sequencer to the datapath and pin decode
  typedef struct packed {
    logic loadReq;
    logic capRead;
    logic phAddr;
    logic phRead;
    logic phWrite;
  } mwb_strobe_t;

  localparam logic [1:0] WE_FULL = 2'd0;
  localparam logic [1:0] WE_LOW  = 2'd1;
  localparam logic [1:0] WE_HIGH = 2'd2;

endpackage

// File: rtl/mwb_ctrl.sv
module mwb_ctrl
  import mwb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqByte,
  output mwb_strobe_t strobe,
  output logic        rspDone
);

  mwb_state_e state, nextState;
  logic opWrite, opByte;
  logic doneNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opWrite <= 1'b0;
      opByte  <= 1'b0;
      rspDone <= 1'b0;
    end else begin
      state   <= nextState;
      rspDone <= doneNext;
      if (strobe.loadReq) begin
        opWrite <= reqWrite;
        opByte  <= reqByte;
      end
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strobe.loadReq = reqValid;
        if (reqValid) nextState = ST_ADDR;
      end
      ST_ADDR: begin
        strobe.phAddr = 1'b1;
        // a full-word store needs no read; a byte store reads first (R6)
        nextState = (opWrite && !opByte) ? ST_WRITE : ST_READ;
      end
      ST_READ: begin
        strobe.phRead  = 1'b1;
        strobe.capRead = 1'b1;
        nextState      = opWrite ? ST_WRITE : ST_IDLE;
        doneNext       = !opWrite;
      end
      ST_WRITE: begin
        strobe.phWrite = 1'b1;
        nextState      = ST_IDLE;
        doneNext       = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/mwb_datapath.sv
module mwb_datapath
  import mwb_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwb_strobe_t       strobe,
  input  logic [BUS_W-1:0]  reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  input  logic              reqByte,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic [BUS_W-1:0]  rspRdata
);

  localparam int LANES = BUS_W / LANE_W;
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [BUS_W-1:0]  addrReg, wdataReg, rdWord, writeWord;
  logic              byteReg;
  logic [SEL_W-1:0]  laneSel;
  logic [LANE_W-1:0] laneData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      byteReg  <= 1'b0;
      rdWord   <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
        byteReg  <= reqByte;
      end
      if (strobe.capRead) rdWord <= busIn;
    end
  end

  assign laneSel = addrReg[SEL_W-1:0];

  // lane merge for stores: the selected lane takes the low byte of the
  // write data, every other lane keeps what was just read (R6)
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign writeWord[g*LANE_W +: LANE_W] =
        !byteReg                  ? wdataReg[g*LANE_W +: LANE_W] :
        (laneSel == SEL_W'(g))    ? wdataReg[LANE_W-1:0]         :
                                    rdWord[g*LANE_W +: LANE_W];
  end

  always_comb begin
    laneData = '0;
    for (int i = 0; i < LANES; i++) begin
      if (laneSel == SEL_W'(i)) laneData = rdWord[i*LANE_W +: LANE_W];
    end
  end

  assign rspRdata = byteReg ? {{(BUS_W-LANE_W){1'b0}}, laneData} : rdWord;

  always_comb begin
    if (strobe.phAddr)       busOut = {addrReg[BUS_W-1:SEL_W], {SEL_W{1'b0}}};
    else if (strobe.phWrite) busOut = writeWord;
    else                     busOut = '0;
  end

endmodule

// File: rtl/mux_word_bus.sv
module mux_word_bus
  import mwb_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [BUS_W-1:0]  reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  input  logic [1:0]        weMode,
  output logic [BUS_W-1:0]  rspRdata,
  output logic              rspDone,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic              busDirIn,
  output logic              ale,
  output logic              oeN,
  output logic              weN
);

  mwb_strobe_t strobe;

  mwb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqByte  (reqByte),
    .strobe   (strobe),
    .rspDone  (rspDone)
  );

  mwb_datapath #(.BUS_W(BUS_W), .LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqByte  (reqByte),
    .busIn    (busIn),
    .busOut   (busOut),
    .rspRdata (rspRdata)
  );

  assign ale      = strobe.phAddr;
  assign oeN      = !strobe.phRead;
  assign busDirIn = !(strobe.phAddr || strobe.phWrite);

  // write strobe shaping (R7)
  always_comb begin
    unique case (weMode)
      WE_LOW:  weN = !(strobe.phWrite && !clk);
      WE_HIGH: weN = !(strobe.phWrite && clk);
      default: weN = !strobe.phWrite;
    endcase
  end

endmodule

// File: rtl/mux_word_bus_chk.sv
module mux_word_bus_chk (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic oeN,
  input logic weN,
  input logic busDirIn,
  input logic rspDone
);

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (!busDirIn && oeN));

  p_read_phase_r3: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (busDirIn && !ale));

  p_read_then_write_or_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |=> (rspDone || (!busDirIn && !ale)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  p_no_strobe_overlap_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN));

endmodule

bind mux_word_bus mux_word_bus_chk chk_i (.*);

// File: tb/mux_word_bus_tb_top.sv
module mux_word_bus_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqByte;
  logic [15:0] reqAddr, reqWdata;
  logic [1:0]  weMode;
  logic [15:0] rspRdata, busIn, busOut;
  logic        rspDone, busDirIn, ale, oeN, weN;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit started  = 1'b0;

  always #5 clk = ~clk;

  mux_word_bus dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqByte(reqByte), .reqAddr(reqAddr), .reqWdata(reqWdata), .weMode(weMode),
    .rspRdata(rspRdata), .rspDone(rspDone), .busIn(busIn), .busOut(busOut),
    .busDirIn(busDirIn), .ale(ale), .oeN(oeN), .weN(weN)
  );

  // external memory model: transparent address latch plus word RAM
  logic [15:0] mem    [256];
  logic [15:0] shadow [256];
  logic [14:0] latchAddr = '0;
  logic [15:0] capBus;
  logic [14:0] capAddr;

  always @(ale or busOut) if (ale) latchAddr = busOut[15:1];
  assign busIn = mem[latchAddr[7:0]];
  always @(posedge clk) begin #2; capBus = busOut; capAddr = latchAddr; end
  always @(posedge weN) if (started) mem[capAddr[7:0]] = capBus;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // phase codes
  localparam int PH_ADDR = 0, PH_READ = 1, PH_WRITE = 2, PH_DONE = 3;

  task automatic access(input logic w, input logic b, input logic [1:0] mode,
                        input logic [15:0] a, input logic [15:0] d);
    int total;
    logic [15:0] old, expWr, expRd;
    logic weHi, weHiExp, weLoExp;
    old   = shadow[a[8:1]];
    expWr = !b ? d : (a[0] ? {d[7:0], old[7:0]} : {old[15:8], d[7:0]});
    expRd = !b ? old : (a[0] ? {8'h00, old[15:8]} : {8'h00, old[7:0]});
    weHiExp = (mode == 2'd1);
    weLoExp = (mode == 2'd2);
    total = (w && b) ? 4 : 3;
    weMode = mode; reqWrite = w; reqByte = b; reqAddr = a; reqWdata = d;
    reqValid = 1'b1;
    @(posedge clk); #2;
    reqValid = 1'b0;
    for (int n = 1; n <= total; n++) begin
      int ph;
      weHi = weN;
      #5;
      if (n == 1) ph = PH_ADDR;
      else if (n == total) ph = PH_DONE;
      else if (!w) ph = PH_READ;
      else if (!b) ph = PH_WRITE;
      else ph = (n == 2) ? PH_READ : PH_WRITE;
      case (ph)
        PH_ADDR: begin
          chk("R2 addr phase ctl", {11'd0, ale, oeN, busDirIn, weHi, weN}, {11'd0, 5'b11011});
          chk("R2 addr on bus", busOut, {a[15:1], 1'b0});
        end
        PH_READ: chk(b && w ? "R6 rmw read ctl" : "R3 read ctl",
                     {11'd0, ale, oeN, busDirIn, weHi, weN}, {11'd0, 5'b00111});
        PH_WRITE: begin
          chk("R5 write ctl", {13'd0, ale, oeN, busDirIn}, {13'd0, 3'b010});
          chk("R7 we shape", {14'd0, weHi, weN}, {14'd0, weHiExp, weLoExp});
          chk(b ? "R6 merged word" : "R5 write word", busOut, expWr);
        end
        default: begin
          chk(w && b ? "R6 done" : (w ? "R5 done" : "R3 done"),
              {12'd0, ale, oeN, busDirIn, rspDone}, {12'd0, 4'b0111});
          if (!w) chk(b ? "R4 byte read data" : "R3 word read data", rspRdata, expRd);
        end
      endcase
      @(posedge clk); #2;
    end
    #5;
    chk("R8 done one cycle", {15'd0, rspDone}, 16'd0);
    if (w) shadow[a[8:1]] = expWr;
    @(posedge clk); #2;
  endtask

  // w, b, mode, addr, data
  localparam logic [35:0] VECS [15] = '{
    {1'b1, 1'b0, 2'd0, 16'h0010, 16'hBEEF},
    {1'b0, 1'b0, 2'd0, 16'h0010, 16'h0000},
    {1'b1, 1'b1, 2'd0, 16'h0010, 16'h0012},
    {1'b1, 1'b1, 2'd1, 16'h0011, 16'h0034},
    {1'b0, 1'b0, 2'd0, 16'h0011, 16'h0000},
    {1'b0, 1'b1, 2'd0, 16'h0010, 16'h0000},
    {1'b0, 1'b1, 2'd0, 16'h0011, 16'h0000},
    {1'b0, 1'b0, 2'd0, 16'h0040, 16'h0000},
    {1'b1, 1'b1, 2'd2, 16'h0041, 16'hFF77},
    {1'b0, 1'b0, 2'd0, 16'h0040, 16'h0000},
    {1'b1, 1'b0, 2'd1, 16'h0044, 16'h5AA5},
    {1'b1, 1'b0, 2'd2, 16'h0046, 16'hC33C},
    {1'b1, 1'b0, 2'd3, 16'h0048, 16'h0F0F},
    {1'b1, 1'b1, 2'd2, 16'h0044, 16'h22E1},
    {1'b0, 1'b0, 2'd0, 16'h0044, 16'h0000}
  };

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int aleCount;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 16'(i * 16'h0301) ^ 16'hA5C3;
      shadow[i] = mem[i];
    end
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqByte = 1'b0;
    reqAddr = '0; reqWdata = '0; weMode = 2'd0;
    repeat (3) @(posedge clk);
    #7;
    chk("R1 reset pins", {11'd0, ale, oeN, weN, busDirIn, rspDone}, {11'd0, 5'b01110});
    rstN = 1'b1;
    started = 1'b1;
    @(posedge clk); #7;
    chk("R1 after reset", {11'd0, ale, oeN, weN, busDirIn, rspDone}, {11'd0, 5'b01110});
    @(posedge clk); #2;

    for (int v = 0; v < 15; v++) begin
      access(VECS[v][35], VECS[v][34], VECS[v][33:32], VECS[v][31:16], VECS[v][15:0]);
    end

    // R6: memory holds exactly the merged words
    chk("R6 mem word 08", mem[8'h08], shadow[8'h08]);
    chk("R6 mem word 20", mem[8'h20], shadow[8'h20]);
    chk("R6 mem word 22", mem[8'h22], shadow[8'h22]);

    // R8: request while busy is ignored
    aleCount = 0;
    weMode = 2'd0; reqWrite = 1'b1; reqByte = 1'b0;
    reqAddr = 16'h0020; reqWdata = 16'h1111; reqValid = 1'b1;
    @(posedge clk); #2;
    reqAddr = 16'h0022; reqWdata = 16'h2222;   // held through the address phase
    for (int n = 0; n < 8; n++) begin
      #5;
      if (ale) aleCount++;
      if (n == 0) reqValid = 1'b0;
      @(posedge clk); #2;
    end
    shadow[8'h10] = 16'h1111;
    chk("R8 single address phase", 16'(aleCount), 16'd1);
    chk("R8 first write landed", mem[8'h10], 16'h1111);
    chk("R8 busy request ignored", mem[8'h11], shadow[8'h11]);

    finish_run();
  end

endmodule